// File: doc/BRIEF.md
# Programmable Interval Counter with Staged Reload

An 8-bit up-counter that advances on the falling edge of one tap of a free-running divider. The tap is picked by a two-bit rate field and gated by an enable bit. When the counter passes its maximum it takes the value held in a modulo register. A short reload sequence then follows, and during that sequence the block raises a one-cycle timer request. Next to the request sits a second one-cycle flag. This flag marks the request as one that should be honoured only on the following cycle.

Software reaches the counter, the modulo value and the control field through a small select-based register port. Writes take effect at the clock edge and reads are combinational. Rewriting the control field can remove a high tap level from the enabled-and-selected signal. When that happens the counter takes one extra step, as a real falling edge would cause. An overflow that comes from such a step raises its request without the delay flag. Writing the counter while the reload is still pending abandons that reload.

Top module: `prog_timer`

## Requirements
- R1: After reset the counter, modulo and control values read as zero, and both the request and the delay flag are low.
- R2: The register select is 0 for the counter, 1 for the modulo value and 2 for control (bit 2 enable, bits 1:0 rate). Select 3 always reads zero, and writes to it change nothing. Read data follows the select combinationally.
- R3: The counter advances by one at the clock edge where (enable AND selected divider bit) has just gone from 1 to 0. Rate 0 taps divider bit 9 (period 1024), rate 1 taps bit 3 (16), rate 2 taps bit 5 (64) and rate 3 taps bit 7 (256). With enable clear the counter holds.
- R4: An advance from the all-ones value loads the modulo value at the same edge and enters a pending state. At the next edge the request output goes high for one cycle and the state moves to done. One edge later it returns to running.
- R5: The delay flag is high only together with the request. It is cleared on every other cycle. It is set for requests whose overflow came from a normal tap edge.
- R6: A control write adds exactly one advance at its edge when the old enable and old tap bit were both 1 and either the new enable is 0 or the new tap bit is 0. Any other control write adds no advance.
- R7: An overflow caused by the advance of R6 raises the request with the delay flag low.
- R8: A counter write while the reload is pending cancels it. No request follows, and the counter keeps the written value.
- R9: A counter write has priority over an advance at the same edge, so no overflow takes place in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Free-running divider value |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | CNT_W | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | CNT_W | Read data for rd_sel_i |
| irq_o | output | 1 | One-cycle timer request |
| irq_dly_o | output | 1 | Request is to be honoured one cycle late |

## Verification
The bench builds the block with its default parameters: a 16-bit divider, an 8-bit counter and taps at bits 9, 3, 5 and 7. The 16-cycle rate makes an overflow reachable in a few hundred cycles. The bench drives the divider value itself, so it can place a chosen tap level under a control write. That reaches both the extra-advance case and the no-extra-advance case, and it lets a write land exactly on an overflow edge or on the pending reload that follows.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;

    typedef enum logic [1:0] {
        RLD_RUN  = 2'd0,
        RLD_PEND = 2'd1,
        RLD_DONE = 2'd2
    } rld_state_e;

    localparam logic [1:0] SEL_COUNT = 2'd0;
    localparam logic [1:0] SEL_MOD   = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_EN_BIT = 2;
    localparam int RATE_W      = 2;

endpackage

// File: rtl/prog_timer_tap.sv
module prog_timer_tap
    import prog_timer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int TAP_R0 = 9,
    parameter int TAP_R1 = 3,
    parameter int TAP_R2 = 5,
    parameter int TAP_R3 = 7
) (
    input  logic [DIV_W-1:0]  div_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              bit_o
);
    localparam int NSEL = 1 << RATE_W;

    logic [NSEL-1:0] cand;

    for (genvar g = 0; g < NSEL; g++) begin : g_tap
        localparam int POS = (g == 0) ? TAP_R0 :
                             (g == 1) ? TAP_R1 :
                             (g == 2) ? TAP_R2 : TAP_R3;
        assign cand[g] = div_i[POS];
    end

    assign bit_o = cand[rate_i];

endmodule

// File: rtl/prog_timer_step.sv
module prog_timer_step (
    input  logic en_q,
    input  logic bit_cur,
    input  logic prev_q,
    input  logic ctl_wr,
    input  logic new_en,
    input  logic bit_new,
    output logic inc_o,
    output logic glitch_o,
    output logic prev_d_o
);
    logic tick_cur;
    logic tick_new;

    assign tick_cur = en_q & bit_cur;
    assign tick_new = new_en & bit_new;

    // A control write that pulls a high gated tap low behaves as an edge.
    assign glitch_o = ctl_wr & tick_cur & ~tick_new;
    assign inc_o    = (prev_q & ~tick_cur) | glitch_o;
    // After a control write, edge tracking restarts from the new setting.
    assign prev_d_o = ctl_wr ? tick_new : tick_cur;

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import prog_timer_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 8,
    parameter int TAP_R0 = 9,
    parameter int TAP_R1 = 3,
    parameter int TAP_R2 = 5,
    parameter int TAP_R3 = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    input  logic [1:0]       rd_sel_i,
    output logic [CNT_W-1:0] rd_data_o,
    output logic             irq_o,
    output logic             irq_dly_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam int CTRL_PAD = CNT_W - RATE_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  modulo;
        logic              en;
        logic [RATE_W-1:0] rate;
        logic              prev;
        rld_state_e        rld;
        logic              glitch_ovf;
        logic              irq;
        logic              dly;
    } regs_t;

    localparam regs_t REGS_RST = '0;

    regs_t q, d;

    logic              wr_count, wr_mod, wr_ctrl;
    logic              new_en;
    logic [RATE_W-1:0] new_rate;
    logic              bit_cur, bit_new;
    logic              inc, glitch, prev_d;

    // Observation points for the bound checker
    logic [CNT_W-1:0]  cnt_cur;
    logic              en_cur;
    logic              rld_pend;

    assign wr_count = wr_en_i && (wr_sel_i == SEL_COUNT);
    assign wr_mod   = wr_en_i && (wr_sel_i == SEL_MOD);
    assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign new_en   = wr_data_i[CTRL_EN_BIT];
    assign new_rate = wr_data_i[RATE_W-1:0];

    prog_timer_tap #(
        .DIV_W(DIV_W), .TAP_R0(TAP_R0), .TAP_R1(TAP_R1),
        .TAP_R2(TAP_R2), .TAP_R3(TAP_R3)
    ) u_tap_cur (
        .div_i (div_i),
        .rate_i(q.rate),
        .bit_o (bit_cur)
    );

    prog_timer_tap #(
        .DIV_W(DIV_W), .TAP_R0(TAP_R0), .TAP_R1(TAP_R1),
        .TAP_R2(TAP_R2), .TAP_R3(TAP_R3)
    ) u_tap_new (
        .div_i (div_i),
        .rate_i(new_rate),
        .bit_o (bit_new)
    );

    prog_timer_step u_step (
        .en_q    (q.en),
        .bit_cur (bit_cur),
        .prev_q  (q.prev),
        .ctl_wr  (wr_ctrl),
        .new_en  (new_en),
        .bit_new (bit_new),
        .inc_o   (inc),
        .glitch_o(glitch),
        .prev_d_o(prev_d)
    );

    always_comb begin
        d      = q;
        d.irq  = 1'b0;
        d.dly  = 1'b0;
        d.prev = prev_d;

        if (wr_mod) begin
            d.modulo = wr_data_i;
        end
        if (wr_ctrl) begin
            d.en   = new_en;
            d.rate = new_rate;
        end

        case (q.rld)
            RLD_PEND: begin
                d.irq = 1'b1;
                d.dly = ~q.glitch_ovf;
                d.rld = RLD_DONE;
            end
            RLD_DONE: d.rld = RLD_RUN;
            default:  d.rld = RLD_RUN;
        endcase

        if (wr_count) begin
            d.count = wr_data_i;
            if (q.rld == RLD_PEND) begin
                d.irq = 1'b0;
                d.dly = 1'b0;
                d.rld = RLD_RUN;
            end
        end else if (inc) begin
            if (q.count == CNT_MAX) begin
                d.count      = q.modulo;
                d.rld        = RLD_PEND;
                d.glitch_ovf = glitch;
            end else begin
                d.count = q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rd_sel_i)
            SEL_COUNT: rd_data_o = q.count;
            SEL_MOD:   rd_data_o = q.modulo;
            SEL_CTRL:  rd_data_o = {{CTRL_PAD{1'b0}}, q.en, q.rate};
            default:   rd_data_o = '0;
        endcase
    end

    assign irq_o     = q.irq;
    assign irq_dly_o = q.dly;
    assign cnt_cur   = q.count;
    assign en_cur    = q.en;
    assign rld_pend  = (q.rld == RLD_PEND);

endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       wr_sel_i,
    input logic [CNT_W-1:0] wr_data_i,
    input logic [CNT_W-1:0] cnt_cur,
    input logic             en_cur,
    input logic             rld_pend,
    input logic             irq_o,
    input logic             irq_dly_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (cnt_cur == '0 && !irq_o && !irq_dly_o));

    // R5
    dly_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_dly_o |-> irq_o);

    // R4
    pend_fires_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rld_pend && !(wr_en_i && wr_sel_i == 2'd0)) |=> irq_o);

    // R8
    cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rld_pend && wr_en_i && wr_sel_i == 2'd0) |=> !irq_o);

    // R9
    count_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_sel_i == 2'd0) |=> (cnt_cur == $past(wr_data_i)));

    // R3
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_cur && !wr_en_i) |=> $stable(cnt_cur));

endmodule

bind prog_timer prog_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_sel_i (wr_sel_i),
    .wr_data_i(wr_data_i),
    .cnt_cur  (cnt_cur),
    .en_cur   (en_cur),
    .rld_pend (rld_pend),
    .irq_o    (irq_o),
    .irq_dly_o(irq_dly_o)
);

// File: tb/prog_timer_tb.sv
`timescale 1ns/100ps
module prog_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] div = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        irq, dly;

    int vectors = 0;
    int miscompares = 0;
    int irq_seen = 0;
    int dly_seen = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prog_timer u_dut (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .irq_o(irq), .irq_dly_o(dly)
    );

    // Behavioural reference
    int m_cnt, m_mod, m_en, m_rate, m_prev, m_state, m_gl, m_irq, m_dly;

    function automatic int tap_of(input int r);
        case (r)
            0: return 9;
            1: return 3;
            2: return 5;
            default: return 7;
        endcase
    endfunction

    function automatic int exp_read(input int s);
        case (s)
            0: return m_cnt;
            1: return m_mod;
            2: return m_en * 4 + m_rate;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_mod = 0; m_en = 0; m_rate = 0; m_prev = 0;
            m_state = 0; m_gl = 0; m_irq = 0; m_dly = 0;
        end else begin
            int cur, nt, g, nat, n_cnt, n_state, n_gl, n_irq, n_dly;
            bit wc;
            cur = (m_en != 0) && div[tap_of(m_rate)];
            wc  = wr_en && wr_sel == 2;
            nt  = wr_data[2] && div[tap_of(int'(wr_data[1:0]))];
            g   = (wc && cur && !nt) ? 1 : 0;
            nat = (m_prev && !cur) ? 1 : 0;
            n_cnt = m_cnt; n_state = m_state; n_gl = m_gl; n_irq = 0; n_dly = 0;
            if (m_state == 1) begin
                n_irq = 1; n_dly = m_gl ? 0 : 1; n_state = 2;
            end else if (m_state == 2) begin
                n_state = 0;
            end
            if (wr_en && wr_sel == 0) begin
                n_cnt = wr_data;
                if (m_state == 1) begin n_irq = 0; n_dly = 0; n_state = 0; end
            end else if (nat || g) begin
                if (m_cnt == 255) begin
                    n_cnt = m_mod; n_state = 1; n_gl = g;
                end else begin
                    n_cnt = m_cnt + 1;
                end
            end
            if (wr_en && wr_sel == 1) m_mod = wr_data;
            if (wc) begin m_en = wr_data[2]; m_rate = wr_data[1:0]; end
            m_prev = wc ? nt : cur;
            m_cnt = n_cnt; m_state = n_state; m_gl = n_gl; m_irq = n_irq; m_dly = n_dly;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 request", {7'b0, irq}, 8'(m_irq));
            chk("R5 delay flag", {7'b0, dly}, 8'(m_dly));
            chk("R2 read data", rd_data, 8'(exp_read(int'(rd_sel))));
            if (irq) irq_seen++;
            if (dly) dly_seen++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            wr_en = 1'b0; div = div + 1'b1; rd_sel = rd_sel + 1'b1;
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = v; div = div + 1'b1;
    endtask

    task automatic wr_div(input logic [1:0] s, input logic [7:0] v, input logic [15:0] dv);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_sel = s; wr_data = v; div = dv;
    endtask

    task automatic peek(input string req, input logic [1:0] s, input logic [7:0] exp);
        @(negedge clk); #1;
        wr_en = 1'b0; div = div + 1'b1; rd_sel = s;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    initial begin
        int i0, d0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        peek("R1 count after reset", 2'd0, 8'h00);
        peek("R1 modulo after reset", 2'd1, 8'h00);
        peek("R1 control after reset", 2'd2, 8'h00);
        chk("R1 request after reset", {7'b0, irq}, 8'h00);

        // R2 register map
        wr(2'd1, 8'hA5);
        peek("R2 modulo readback", 2'd1, 8'hA5);
        wr(2'd2, 8'h06);
        peek("R2 control readback", 2'd2, 8'h06);
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'h3C);
        wr(2'd3, 8'hFF);
        peek("R2 select 3 reads zero", 2'd3, 8'h00);
        peek("R2 select 3 write ignored", 2'd0, 8'h3C);

        // R3 disabled hold, then rate 1 stepping
        wr(2'd0, 8'h10);
        idle(2000);
        peek("R3 disabled counter holds", 2'd0, 8'h10);
        wr_div(2'd2, 8'h05, 16'h0000);
        idle(64);
        peek("R3 four edges at rate 1", 2'd0, 8'h14);

        // R4 / R5 normal overflow
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'hFE);
        wr(2'd1, 8'hF0);
        wr_div(2'd2, 8'h05, 16'h0000);
        i0 = irq_seen; d0 = dly_seen;
        idle(32);
        idle(4);
        peek("R4 count reloaded from modulo", 2'd0, 8'hF0);
        chk("R4 one request", 8'(irq_seen - i0), 8'd1);
        chk("R5 delay flag with request", 8'(dly_seen - d0), 8'd1);

        // R6 / R7 write-time advance causing overflow
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h33);
        wr_div(2'd2, 8'h05, 16'h0000);
        i0 = irq_seen; d0 = dly_seen;
        wr_div(2'd2, 8'h00, 16'h0008);
        idle(4);
        peek("R6 extra advance reloads", 2'd0, 8'h33);
        chk("R7 request from extra advance", 8'(irq_seen - i0), 8'd1);
        chk("R7 no delay flag", 8'(dly_seen - d0), 8'd0);

        // R6 no extra advance when the new tap stays high
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'h40);
        wr_div(2'd2, 8'h05, 16'h0008);
        wr_div(2'd2, 8'h06, 16'h0028);
        peek("R6 no advance new tap high", 2'd0, 8'h40);

        // R6 extra advance when new tap is low while enabled
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'h60);
        wr_div(2'd2, 8'h05, 16'h0008);
        wr_div(2'd2, 8'h04, 16'h0008);
        peek("R6 advance new tap low", 2'd0, 8'h61);

        // R8 cancel pending reload
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h80);
        wr_div(2'd2, 8'h05, 16'h0000);
        i0 = irq_seen;
        idle(16);
        wr(2'd0, 8'h22);
        idle(4);
        peek("R8 written value kept", 2'd0, 8'h22);
        chk("R8 no request after cancel", 8'(irq_seen - i0), 8'd0);

        // R9 write beats advance
        wr_div(2'd2, 8'h00, 16'h0000);
        wr(2'd0, 8'hFF);
        wr_div(2'd2, 8'h05, 16'h0000);
        i0 = irq_seen;
        idle(15);
        wr(2'd0, 8'h55);
        idle(3);
        peek("R9 write wins over overflow", 2'd0, 8'h55);
        chk("R9 no request", 8'(irq_seen - i0), 8'd0);

        // Mixed traffic on all rates, checked against the reference each cycle
        for (int k = 0; k < 120; k++) begin
            int s;
            s = $urandom_range(0, 3);
            case (s)
                0: wr(2'd2, 8'($urandom_range(0, 7)));
                1: wr(2'd0, 8'($urandom_range(240, 255)));
                2: wr(2'd1, 8'($urandom_range(0, 255)));
                default: wr(2'd3, 8'hAA);
            endcase
            idle($urandom_range(1, 60));
        end
        wr(2'd2, 8'h04);
        idle(3000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule